// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Supervisor

This block is the digital control core of a five-rail regulator. It watches a battery-supply comparator pair, a die-temperature flag and, for each rail, comparator flags for overvoltage, undervoltage and in-window status. For the two buck main rails it also watches an overcurrent flag. From these it produces the enables for the two always-on linear rails, the two main buck rails (5 V and 3.3 V) and the 12 V boost rail, together with an active-low power-good output. The comparators, the references and the gate drivers are outside the block and appear only as flag inputs and enable outputs.

Each main rail has an internal soft-start counter that stands for the capacitor ramp. Undervoltage checking on a rail is armed only once its counter reaches its terminal count. Overvoltage, armed undervoltage and over-temperature latch the whole block off. Overcurrent gets a grace window of a few clock cycles and then shuts down only the rail concerned. All latched faults clear only when the supply comparator drops out or on reset.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, all enables are 0 and `pwr_good_n` is 0.
- R2: The supply is qualified when `sup_above_rise` is 1, `sup_above_fall` is 1 and `temp_hot` is 0. Once qualified it stays qualified while `sup_above_fall` is 1, even after `sup_above_rise` goes to 0. It is lost on the edge after `sup_above_fall` is 0.
- R3: With the supply qualified, no latched fault and `en_all` = 1, both bits of `aon_en` are 1. With `en_all` = 0, every enable output is 0.
- R4: `main_en[0]` (5 V rail) follows `en_5v` and `main_en[1]` (3.3 V rail) follows `en_3v`, each gated by R3 and by its own overcurrent trip. `boost_en` always equals `main_en[0]`.
- R5: Each main rail's soft-start counter restarts at 0 while the rail is off. It counts one step per cycle while the rail is on, up to SS_LEN. Undervoltage flags for that rail are ignored until the count reaches SS_LEN. The boost rail uses the 5 V rail's count.
- R6: A 1 on any bit of `ov_flag` while the supply is qualified turns off every enable from the next edge, and the block stays off.
- R7: An undervoltage flag on an armed rail (bit 2 = 5 V main, bit 3 = 3.3 V main, bit 4 = boost) latches every enable off. Bits 0 and 1 of `uv_flag` are not used.
- R8: When `oc_flag[i]` is first seen on an enabled main rail, a window of OC_WIN cycles starts. If the flag is 1 at the end of the window, that rail alone is turned off and latched off. Otherwise the window closes and the rail keeps running.
- R9: `temp_hot` = 1 while the supply is qualified latches every enable off.
- R10: Latched faults and overcurrent trips survive enable-pin toggling. They clear only when the supply is lost or on reset.
- R11: `pwr_good_n` goes high only when the block is running, both main rails are enabled and have finished soft start, and all five `win_flag` bits are 1.
- R12: Each time the R11 condition fails, even for a single cycle, `pwr_good_n` stays low for at least PG_MIN consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_all | input | 1 | Master enable |
| en_5v | input | 1 | Enable for the 5 V main rail |
| en_3v | input | 1 | Enable for the 3.3 V main rail |
| sup_above_rise | input | 1 | Supply is above the rising threshold |
| sup_above_fall | input | 1 | Supply is above the falling threshold |
| temp_hot | input | 1 | Die over-temperature |
| ov_flag | input | 5 | Per-rail overvoltage (0 aon5, 1 aon3, 2 main5, 3 main3, 4 boost) |
| uv_flag | input | 5 | Per-rail undervoltage, same indexing |
| win_flag | input | 5 | Per-rail output inside its power-good window |
| oc_flag | input | 2 | Overcurrent on main rails (0 = 5 V, 1 = 3.3 V) |
| aon_en | output | 2 | Always-on rail enables |
| main_en | output | 2 | Main buck rail enables (0 = 5 V, 1 = 3.3 V) |
| boost_en | output | 1 | Boost rail enable |
| pwr_good_n | output | 1 | Power-good, low when outputs are not good |

## Verification
Two kinds of event can fall on the same clock edge: the end of an overcurrent window, which sets a rail trip, and the loss of the supply, which clears every trip and fault. The same holds for the edge where a rail's undervoltage check becomes armed and an undervoltage flag is present on that edge. Random stimulus keeps overcurrent pulses, undervoltage pulses and periodic supply dropouts running against each other until these edges coincide. A cycle-level reference model in the bench, written from the requirements, judges every enable and the power-good output on every cycle. Directed sequences pin down the grace window, the stretch width and the restart that stays blocked while the die is hot.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NUM_RAILS = 5;
    localparam int NUM_MAIN  = 2;

    typedef enum logic [2:0] {
        RAIL_AON5  = 3'd0,
        RAIL_AON3  = 3'd1,
        RAIL_MAIN5 = 3'd2,
        RAIL_MAIN3 = 3'd3,
        RAIL_BOOST = 3'd4
    } rail_e;

    typedef struct packed {
        logic qualified;
        logic latched_off;
    } sup_state_t;

    // undervoltage arming mask: main rails armed by their own soft start,
    // boost armed together with the 5 V main rail
    function automatic logic [NUM_RAILS-1:0] uv_arm_mask(input logic [NUM_MAIN-1:0] armed);
        logic [NUM_RAILS-1:0] m;
        m = '0;
        m[RAIL_MAIN5] = armed[0];
        m[RAIL_MAIN3] = armed[1];
        m[RAIL_BOOST] = armed[0];
        return m;
    endfunction

endpackage

// File: rtl/rs_rail_ctl.sv
module rs_rail_ctl #(
    parameter int SS_LEN = 16,
    parameter int OC_WIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_ok,
    input  logic rail_on,
    input  logic oc_in,
    output logic ss_done,
    output logic trip
);
    localparam int SSW = $clog2(SS_LEN + 1);
    localparam int OCW = $clog2(OC_WIN + 1);
    localparam logic [SSW-1:0] SS_TOP = SSW'(SS_LEN);
    localparam logic [OCW-1:0] OC_TOP = OCW'(OC_WIN);

    logic [SSW-1:0] ss_cnt;
    logic [OCW-1:0] oc_cnt;
    logic           trip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_cnt <= '0;
            oc_cnt <= '0;
            trip_q <= 1'b0;
        end else begin
            if (!rail_on)              ss_cnt <= '0;
            else if (ss_cnt != SS_TOP) ss_cnt <= ss_cnt + 1'b1;

            if (!rail_on)              oc_cnt <= '0;
            else if (oc_cnt == '0)     oc_cnt <= oc_in ? OCW'(1) : '0;
            else if (oc_cnt == OC_TOP) oc_cnt <= '0;
            else                       oc_cnt <= oc_cnt + 1'b1;

            if (!sup_ok)                                    trip_q <= 1'b0;
            else if (rail_on && oc_cnt == OC_TOP && oc_in)  trip_q <= 1'b1;
        end
    end

    assign ss_done = (ss_cnt == SS_TOP);
    assign trip    = trip_q;

    // R8
    oc_window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        oc_cnt <= OC_TOP);
    // R8
    oc_trip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_q) |-> ($past(oc_in) && $past(rail_on)));
    // R5
    ss_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_on) |-> (ss_cnt == '0));
    // R10
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_q && sup_ok) |=> trip_q);

endmodule

// File: rtl/rs_pg_stretch.sv
module rs_pg_stretch #(
    parameter int PG_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic good,
    output logic pg_n
);
    localparam int PW = (PG_MIN < 2) ? 1 : $clog2(PG_MIN + 1);
    localparam logic [PW-1:0] HOLD = PW'(PG_MIN - 1);

    logic [PW-1:0] hold_cnt;
    logic          pg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            pg_q     <= 1'b0;
        end else if (!good) begin
            hold_cnt <= HOLD;
            pg_q     <= 1'b0;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else begin
            pg_q <= 1'b1;
        end
    end

    assign pg_n = pg_q;

    // R12
    pg_rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_q) |-> ($past(good) && $past(hold_cnt) == '0));
    // R12
    pg_drop_load_chk: assert property (@(posedge clk) disable iff (rst)
        !good |=> (!pg_q && hold_cnt == HOLD));

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
    import rs_pkg::*;
#(
    parameter int SS_LEN = 16,
    parameter int OC_WIN = 8,
    parameter int PG_MIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_all,
    input  logic       en_5v,
    input  logic       en_3v,
    input  logic       sup_above_rise,
    input  logic       sup_above_fall,
    input  logic       temp_hot,
    input  logic [4:0] ov_flag,
    input  logic [4:0] uv_flag,
    input  logic [4:0] win_flag,
    input  logic [1:0] oc_flag,
    output logic [1:0] aon_en,
    output logic [1:0] main_en,
    output logic       boost_en,
    output logic       pwr_good_n
);
    sup_state_t           st_q;
    logic                 run;
    logic [NUM_MAIN-1:0]  pin_en, men, ss_done, trip, armed;
    logic [NUM_RAILS-1:0] uv_live;
    logic                 fault_set, good;

    assign pin_en = {en_3v, en_5v};
    assign run    = st_q.qualified & en_all & ~st_q.latched_off;

    for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
        assign men[g]   = run & pin_en[g] & ~trip[g];
        assign armed[g] = men[g] & ss_done[g];
        rs_rail_ctl #(.SS_LEN(SS_LEN), .OC_WIN(OC_WIN)) u_rail (
            .clk     (clk),
            .rst     (rst),
            .sup_ok  (st_q.qualified),
            .rail_on (men[g]),
            .oc_in   (oc_flag[g]),
            .ss_done (ss_done[g]),
            .trip    (trip[g])
        );
    end

    assign uv_live   = uv_flag & uv_arm_mask(armed);
    assign fault_set = st_q.qualified & ((|ov_flag) | temp_hot | (|uv_live));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (!sup_above_fall)                  st_q.qualified <= 1'b0;
            else if (sup_above_rise && !temp_hot) st_q.qualified <= 1'b1;

            if (!st_q.qualified) st_q.latched_off <= 1'b0;
            else if (fault_set)  st_q.latched_off <= 1'b1;
        end
    end

    assign good = run & (&men) & (&ss_done) & (&win_flag);

    rs_pg_stretch #(.PG_MIN(PG_MIN)) u_pg (
        .clk  (clk),
        .rst  (rst),
        .good (good),
        .pg_n (pwr_good_n)
    );

    assign aon_en   = {2{run}};
    assign main_en  = men;
    assign boost_en = men[0];

    // R6
    ov_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.qualified && (|ov_flag)) |=> (aon_en == 2'b00 && main_en == 2'b00 && !boost_en));
    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.latched_off && st_q.qualified) |=> st_q.latched_off);
    // R11
    pg_after_ss_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good_n) |-> $past(&ss_done));
    // R2
    sup_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !sup_above_fall |=> (aon_en == 2'b00));

endmodule

// File: tb/tb_rail_supervisor.sv
`timescale 1ns/1ps
module tb_rail_supervisor;
    localparam int SS = 16;
    localparam int OCW = 8;
    localparam int PGM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_all = 0, en_5v = 0, en_3v = 0, sr = 0, sf = 0, hot = 0;
    logic [4:0] ov = '0, uv = '0, win = 5'h1f;
    logic [1:0] oc = '0;
    logic [1:0] aon_en, main_en;
    logic boost_en, pwr_good_n;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rail_supervisor #(.SS_LEN(SS), .OC_WIN(OCW), .PG_MIN(PGM)) dut (
        .clk(clk), .rst(rst), .en_all(en_all), .en_5v(en_5v), .en_3v(en_3v),
        .sup_above_rise(sr), .sup_above_fall(sf), .temp_hot(hot),
        .ov_flag(ov), .uv_flag(uv), .win_flag(win), .oc_flag(oc),
        .aon_en(aon_en), .main_en(main_en), .boost_en(boost_en), .pwr_good_n(pwr_good_n));

    // reference model state
    int m_sok, m_flt, m_pgc, m_pgn;
    int m_trip[2], m_oc[2], m_ss[2];

    function automatic bit f_run();
        return m_sok != 0 && en_all && m_flt == 0;
    endfunction
    function automatic bit f_men(input int i);
        bit p;
        p = (i == 0) ? en_5v : en_3v;
        return f_run() && p && m_trip[i] == 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sok = 0; m_flt = 0; m_pgc = 0; m_pgn = 0;
            for (int i = 0; i < 2; i++) begin m_trip[i] = 0; m_oc[i] = 0; m_ss[i] = 0; end
        end else begin
            bit run, good, uvf;
            bit men[2];
            int n_sok, n_flt;
            run = f_run();
            men[0] = f_men(0); men[1] = f_men(1);
            uvf = (men[0] && m_ss[0] == SS && (uv[2] || uv[4])) || (men[1] && m_ss[1] == SS && uv[3]);
            good = run && men[0] && men[1] && m_ss[0] == SS && m_ss[1] == SS && win == 5'h1f;
            n_flt = (m_sok == 0) ? 0 : ((m_flt != 0 || (|ov) || hot || uvf) ? 1 : 0);
            n_sok = !sf ? 0 : ((sr && !hot) ? 1 : m_sok);
            for (int i = 0; i < 2; i++) begin
                if (m_sok == 0) m_trip[i] = 0;
                else if (men[i] && m_oc[i] == OCW && oc[i]) m_trip[i] = 1;
                if (!men[i]) m_oc[i] = 0;
                else if (m_oc[i] == 0) m_oc[i] = oc[i] ? 1 : 0;
                else if (m_oc[i] == OCW) m_oc[i] = 0;
                else m_oc[i] = m_oc[i] + 1;
                if (!men[i]) m_ss[i] = 0;
                else if (m_ss[i] < SS) m_ss[i] = m_ss[i] + 1;
            end
            if (!good) begin m_pgc = PGM - 1; m_pgn = 0; end
            else if (m_pgc != 0) m_pgc = m_pgc - 1;
            else m_pgn = 1;
            m_sok = n_sok; m_flt = n_flt;
        end
    end

    // per-cycle comparison against the model, plus watchdog
    always @(negedge clk) begin
        if (!rst && !done) begin
            int e_aon, e_main;
            cyc++;
            e_aon  = f_run() ? 3 : 0;
            e_main = {30'd0, f_men(1), f_men(0)};
            chk(aon_en == e_aon[1:0], "R3 aon_en", aon_en, e_aon);
            chk(main_en == e_main[1:0], "R4 main_en", main_en, e_main);
            chk(boost_en == f_men(0), "R4 boost_en", boost_en, f_men(0));
            chk(pwr_good_n == m_pgn[0], "R11 pwr_good_n", pwr_good_n, m_pgn);
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog act=%0d exp=0", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic cycle_supply();
        sf = 0; step(2);
        sf = 1; sr = 1; step(1);
        sr = 0; step(1);
    endtask

    initial begin
        int seed, lowcnt;
        seed = 7;
        void'($urandom(seed));
        step(3);
        rst = 0;
        step(1);
        // R1
        chk(aon_en == 0 && main_en == 0 && !boost_en && !pwr_good_n, "R1 reset state",
            {aon_en, main_en, boost_en, pwr_good_n}, 0);
        sr = 1; sf = 1; step(1); sr = 0; step(2);
        chk(aon_en == 0, "R3 master off", aon_en, 0);
        en_all = 1; step(1);
        chk(aon_en == 3, "R2 supply held after rise flag drops", aon_en, 3);
        en_5v = 1; uv[2] = 1; step(5);
        chk(main_en[0] && boost_en, "R4 5V main with boost", {main_en[0], boost_en}, 3);
        chk(aon_en == 3, "R5 uv ignored in soft start", aon_en, 3);
        uv = '0; en_3v = 1; step(SS + PGM + 3);
        chk(pwr_good_n == 1, "R11 pg after soft start", pwr_good_n, 1);
        // R12 single-cycle glitch stretched
        win[1] = 0; step(1); win = 5'h1f;
        lowcnt = 0;
        for (int k = 0; k < PGM + 3; k++) begin
            if (!pwr_good_n) lowcnt++;
            step(1);
        end
        chk(lowcnt == PGM, "R12 pg low width", lowcnt, PGM);
        // R8 short overcurrent tolerated
        oc[0] = 1; step(3); oc = '0; step(12);
        chk(main_en[0] == 1, "R8 short oc tolerated", main_en[0], 1);
        oc[0] = 1; step(OCW + 3); oc = '0;
        chk(main_en == 2'b10 && !boost_en, "R8 oc trip on one rail", {main_en, boost_en}, 4);
        en_5v = 0; step(2); en_5v = 1; step(2);
        chk(main_en[0] == 0, "R10 trip survives pin toggle", main_en[0], 0);
        sf = 0; step(2);
        chk(aon_en == 0, "R2 supply loss", aon_en, 0);
        sf = 1; sr = 1; step(1); sr = 0; step(2);
        chk(main_en[0] == 1, "R10 trip cleared by supply loss", main_en[0], 1);
        step(SS + 3);
        ov[3] = 1; step(1); ov = '0; step(2);
        chk(aon_en == 0 && main_en == 0, "R6 ov shutdown", {aon_en, main_en}, 0);
        en_all = 0; step(2); en_all = 1; step(3);
        chk(aon_en == 0, "R10 fault survives master toggle", aon_en, 0);
        cycle_supply();
        step(SS + 3);
        uv[3] = 1; step(1); uv = '0; step(1);
        chk(aon_en == 0, "R7 armed uv shutdown", aon_en, 0);
        cycle_supply();
        hot = 1; step(2);
        chk(aon_en == 0, "R9 thermal shutdown", aon_en, 0);
        sf = 0; step(2); sf = 1; sr = 1; step(2);
        chk(aon_en == 0, "R2 restart blocked while hot", aon_en, 0);
        hot = 0; step(2); sr = 0;
        chk(aon_en == 3, "R2 restart when cool", aon_en, 3);
        en_all = 0; step(1);
        chk(aon_en == 0 && main_en == 0 && !boost_en, "R3 master off", {aon_en, main_en, boost_en}, 0);
        en_all = 1;
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(49) == 0) en_5v = ~en_5v;
            if ($urandom_range(49) == 0) en_3v = ~en_3v;
            if ($urandom_range(199) == 0) en_all = ~en_all;
            ov  = ($urandom_range(399) == 0) ? 5'(1 << $urandom_range(4)) : 5'h0;
            uv  = ($urandom_range(249) == 0) ? 5'(1 << $urandom_range(4)) : 5'h0;
            win = ($urandom_range(39) == 0) ? ~5'(1 << $urandom_range(4)) : 5'h1f;
            if ($urandom_range(29) == 0) oc[0] = ~oc[0];
            if ($urandom_range(29) == 0) oc[1] = ~oc[1];
            hot = ($urandom_range(799) == 0);
            sr  = ($urandom_range(2) == 0);
            sf  = !((n % 300) < 3);
            step(1);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule